// File: doc/BRIEF.md
# DIMM Rank Boundary Calculator

This block turns decoded memory-module geometry for a row of module sockets into the values a memory controller needs for its address map. For each socket it receives a presence bit and the raw row, column, bank-count, data-width and rank-code fields. From these it works out the base-2 logarithm of each rank side's capacity in bits. It then adds the module sizes, in 64 MiB units, into a running total that becomes the cumulative rank boundaries, a top-of-memory value and a top-of-low-memory value.

A request is offered with `in_valid` while `in_ready` is high. The captured fields are then walked one socket per cycle, lowest socket first, and the results are loaded into the output registers together with a one-cycle `done` pulse. When any populated socket carries an invalid field or is too small, the run still takes the same number of cycles, but it ends with `size_err` set and every result output at zero.

Top module: `rank_boundary_calc`

## Requirements
- R1: For a populated socket, side 1's log2 size is the low nibble of the row field, plus the low nibble of the column field, plus floor(log2(bank count)), plus 6. It appears on `side_log2[i*12 +: 6]`. An empty socket reports 0 for both sides.
- R2: For a dual-rank module, side 2's log2 size appears on `side_log2[i*12+6 +: 6]`. It equals side 1's size when the row field's upper nibble is zero. Otherwise, the upper nibbles of the row and column fields replace the lower nibbles in the sum. A single-rank module reports 0 for side 2.
- R3: A populated socket with any of the following raises `size_err` at `done`: a zero row low nibble, a zero column low nibble, a zero bank count, a data width other than 64 or 72, or a rank code (low 3 bits of the rank field) above 1. All result outputs are then zero.
- R4: A populated socket whose side-1 log2 size is below 29 raises `size_err`, and all result outputs are zero.
- R5: A module adds 2^(log2 size − 29) to the running total. Both boundary bytes of socket i (`bound_bytes[i*16 +: 8]` and `[i*16+8 +: 8]`) carry the low 8 bits of the total after that addition. An empty socket repeats the previous total. After a dual-rank module (rank code 1), the total is doubled.
- R6: `top_mem` is the final total shifted right by one.
- R7: `top_low_mem` is `top_mem` clamped to at most 24 (0x18), then shifted left by 11.
- R8: `in_ready` is high only when idle. A request is accepted on a clock edge with `in_valid` and `in_ready` high. `done` is high for exactly one cycle, NSOCK+1 cycles after the accepting edge. Input changes after acceptance have no effect on that run.
- R9: After reset, `in_ready` is 1, and `done`, `size_err` and all result outputs are 0.
- R10: Results and `size_err` hold steady while idle. A newly accepted request clears `size_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request can be taken |
| slot_present | input | NSOCK | Bit i set when socket i holds a module |
| row_bits_fld | input | NSOCK*8 | Row field per socket, socket i at [i*8 +: 8] |
| col_bits_fld | input | NSOCK*8 | Column field per socket |
| bank_cnt_fld | input | NSOCK*8 | Banks per device |
| data_width_fld | input | NSOCK*16 | Module data width in bits, socket i at [i*16 +: 16] |
| rank_code_fld | input | NSOCK*3 | Rank code (ranks minus one), socket i at [i*3 +: 3] |
| done | output | 1 | One-cycle completion pulse |
| size_err | output | 1 | Run ended with an invalid or undersized module |
| bound_bytes | output | NSOCK*16 | Two boundary bytes per socket |
| side_log2 | output | NSOCK*12 | Side-1 and side-2 log2 sizes per socket |
| top_mem | output | 16 | Top of memory, 128 MiB units |
| top_low_mem | output | 16 | Top of low memory |

## Verification
Every result is due on the same cycle: the clock edge NSOCK+1 edges after the accepting edge loads all outputs and raises `done`. Error runs keep this latency. After each accepted request, the bench samples `done` at the falling edge following each of the next four rising edges. It expects `done` high only at the last of these samples, and it compares the result outputs at that same falling edge. Separate directed runs change the inputs while the block is busy, and they sit idle after completion to confirm that the outputs hold.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int FLD_W     = 8;
  localparam int WID_W     = 16;
  localparam int RANK_W    = 3;
  localparam int LOG_W     = 6;
  localparam int MIN_LOG2  = 29;
  localparam int DATA_LOG2 = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } rbc_state_t;

  function automatic logic [3:0] flog2_8(input logic [FLD_W-1:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 0; i < FLD_W; i++)
      if (v[i]) r = 4'(i);
    return r;
  endfunction
endpackage

// File: rtl/rbc_geom_eval.sv
module rbc_geom_eval
  import rbc_pkg::*;
#(
  parameter int TOT_W = 17
) (
  input  logic              present,
  input  logic [FLD_W-1:0]  row_f,
  input  logic [FLD_W-1:0]  col_f,
  input  logic [FLD_W-1:0]  bank_f,
  input  logic [WID_W-1:0]  width_f,
  input  logic [RANK_W-1:0] rank_f,
  output logic [TOT_W-1:0]  units,
  output logic              dual,
  output logic              bad,
  output logic [LOG_W-1:0]  s1_log2,
  output logic [LOG_W-1:0]  s2_log2
);
  logic [LOG_W-1:0] row_lo, row_hi, col_lo, col_hi, bank_l, sum1, sum2;
  logic field_bad, too_small;

  always_comb begin
    row_lo = LOG_W'(row_f[3:0]);
    row_hi = LOG_W'(row_f[7:4]);
    col_lo = LOG_W'(col_f[3:0]);
    col_hi = LOG_W'(col_f[7:4]);
    bank_l = LOG_W'(flog2_8(bank_f));
    sum1   = row_lo + col_lo + bank_l + LOG_W'(DATA_LOG2);

    field_bad = (row_f[3:0] == 4'd0) || (col_f[3:0] == 4'd0) ||
                (bank_f == '0) ||
                !((width_f == WID_W'(64)) || (width_f == WID_W'(72))) ||
                (rank_f > RANK_W'(1));
    too_small = sum1 < LOG_W'(MIN_LOG2);
    bad  = present && (field_bad || too_small);
    dual = (rank_f == RANK_W'(1));

    if (row_f[7:4] != 4'd0)
      sum2 = sum1 - row_lo + row_hi - col_lo + col_hi;
    else
      sum2 = sum1;

    s1_log2 = present ? sum1 : '0;
    s2_log2 = (present && dual) ? sum2 : '0;

    if (present && !bad)
      units = TOT_W'(1) << (sum1 - LOG_W'(MIN_LOG2));
    else
      units = '0;
  end
endmodule

// File: rtl/rbc_limits.sv
module rbc_limits #(
  parameter int TOT_W     = 17,
  parameter int TOM_W     = 16,
  parameter int LOW_CEIL  = 24,
  parameter int LOW_SHIFT = 11
) (
  input  logic [TOT_W-1:0] total,
  output logic [TOM_W-1:0] tom,
  output logic [TOM_W-1:0] tolm
);
  logic [TOM_W-1:0] clamped;

  always_comb begin
    tom     = TOM_W'(total >> 1);
    clamped = (tom > TOM_W'(LOW_CEIL)) ? TOM_W'(LOW_CEIL) : tom;
    tolm    = clamped << LOW_SHIFT;
  end
endmodule

// File: rtl/rank_boundary_calc.sv
module rank_boundary_calc
  import rbc_pkg::*;
#(
  parameter int NSOCK     = 2,
  parameter int BND_W     = 8,
  parameter int TOM_W     = 16,
  parameter int LOW_CEIL  = 24,
  parameter int LOW_SHIFT = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NSOCK-1:0]        slot_present,
  input  logic [NSOCK*FLD_W-1:0]  row_bits_fld,
  input  logic [NSOCK*FLD_W-1:0]  col_bits_fld,
  input  logic [NSOCK*FLD_W-1:0]  bank_cnt_fld,
  input  logic [NSOCK*WID_W-1:0]  data_width_fld,
  input  logic [NSOCK*RANK_W-1:0] rank_code_fld,
  output logic                    done,
  output logic                    size_err,
  output logic [NSOCK*2*BND_W-1:0] bound_bytes,
  output logic [NSOCK*2*LOG_W-1:0] side_log2,
  output logic [TOM_W-1:0]        top_mem,
  output logic [TOM_W-1:0]        top_low_mem
);
  localparam int TOT_W = TOM_W + 1;
  localparam int IDX_W = (NSOCK > 1) ? $clog2(NSOCK) : 1;

  rbc_state_t state;
  logic [IDX_W-1:0] idx;
  logic [TOT_W-1:0] total;
  logic             err_pend;

  logic [NSOCK-1:0]        pres_q;
  logic [NSOCK*FLD_W-1:0]  row_q, col_q, bank_q;
  logic [NSOCK*WID_W-1:0]  wid_q;
  logic [NSOCK*RANK_W-1:0] rank_q;

  logic [TOT_W-1:0] ev_units [NSOCK];
  logic [NSOCK-1:0] ev_dual, ev_bad;
  logic [LOG_W-1:0] ev_s1 [NSOCK];
  logic [LOG_W-1:0] ev_s2 [NSOCK];
  logic [BND_W-1:0] bnd_q [NSOCK];

  logic [TOM_W-1:0] lim_tom, lim_tolm;
  logic [TOT_W-1:0] step_sum;

  genvar g;
  generate
    for (g = 0; g < NSOCK; g++) begin : g_eval
      rbc_geom_eval #(.TOT_W(TOT_W)) eval_i (
        .present (pres_q[g]),
        .row_f   (row_q[g*FLD_W +: FLD_W]),
        .col_f   (col_q[g*FLD_W +: FLD_W]),
        .bank_f  (bank_q[g*FLD_W +: FLD_W]),
        .width_f (wid_q[g*WID_W +: WID_W]),
        .rank_f  (rank_q[g*RANK_W +: RANK_W]),
        .units   (ev_units[g]),
        .dual    (ev_dual[g]),
        .bad     (ev_bad[g]),
        .s1_log2 (ev_s1[g]),
        .s2_log2 (ev_s2[g])
      );
    end
  endgenerate

  rbc_limits #(
    .TOT_W(TOT_W), .TOM_W(TOM_W),
    .LOW_CEIL(LOW_CEIL), .LOW_SHIFT(LOW_SHIFT)
  ) limits_i (
    .total (total),
    .tom   (lim_tom),
    .tolm  (lim_tolm)
  );

  assign in_ready = (state == ST_IDLE);
  assign step_sum = total + ev_units[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      total       <= '0;
      err_pend    <= 1'b0;
      pres_q      <= '0;
      row_q       <= '0;
      col_q       <= '0;
      bank_q      <= '0;
      wid_q       <= '0;
      rank_q      <= '0;
      done        <= 1'b0;
      size_err    <= 1'b0;
      bound_bytes <= '0;
      side_log2   <= '0;
      top_mem     <= '0;
      top_low_mem <= '0;
      for (int i = 0; i < NSOCK; i++) bnd_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            pres_q      <= slot_present;
            row_q       <= row_bits_fld;
            col_q       <= col_bits_fld;
            bank_q      <= bank_cnt_fld;
            wid_q       <= data_width_fld;
            rank_q      <= rank_code_fld;
            total       <= '0;
            idx         <= '0;
            err_pend    <= 1'b0;
            size_err    <= 1'b0;
            bound_bytes <= '0;
            side_log2   <= '0;
            top_mem     <= '0;
            top_low_mem <= '0;
            state       <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (ev_bad[idx]) err_pend <= 1'b1;
          if (pres_q[idx]) begin
            bnd_q[idx] <= BND_W'(step_sum);
            total      <= ev_dual[idx] ? (step_sum << 1) : step_sum;
          end else begin
            bnd_q[idx] <= BND_W'(total);
          end
          if (idx == IDX_W'(NSOCK - 1)) state <= ST_FIN;
          else idx <= idx + IDX_W'(1);
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (err_pend) begin
            size_err <= 1'b1;
          end else begin
            for (int i = 0; i < NSOCK; i++) begin
              bound_bytes[i*2*BND_W +: BND_W]         <= bnd_q[i];
              bound_bytes[i*2*BND_W + BND_W +: BND_W] <= bnd_q[i];
              side_log2[i*2*LOG_W +: LOG_W]           <= ev_s1[i];
              side_log2[i*2*LOG_W + LOG_W +: LOG_W]   <= ev_s2[i];
            end
            top_mem     <= lim_tom;
            top_low_mem <= lim_tolm;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int NSOCK     = 2,
  parameter int BND_W     = 8,
  parameter int TOM_W     = 16,
  parameter int LOW_CEIL  = 24,
  parameter int LOW_SHIFT = 11
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     done,
  input logic                     size_err,
  input logic [NSOCK*2*BND_W-1:0] bound_bytes,
  input logic [TOM_W-1:0]         top_mem,
  input logic [TOM_W-1:0]         top_low_mem
);
  localparam logic [TOM_W-1:0] LOW_MAX = TOM_W'(LOW_CEIL) << LOW_SHIFT;

  assert_err_zeroes_R3: assert property (@(posedge clk) disable iff (rst)
    size_err |-> (top_mem == '0 && top_low_mem == '0 && bound_bytes == '0));

  assert_low_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
    (top_low_mem <= LOW_MAX) && (top_low_mem[LOW_SHIFT-1:0] == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> ($stable(top_mem) && $stable(top_low_mem) &&
                                 $stable(bound_bytes) && $stable(size_err)));

  genvar g;
  generate
    for (g = 0; g < NSOCK; g++) begin : g_pair
      assert_byte_pair_R5: assert property (@(posedge clk) disable iff (rst)
        bound_bytes[g*2*BND_W +: BND_W] == bound_bytes[g*2*BND_W + BND_W +: BND_W]);
    end
  endgenerate
endmodule

bind rank_boundary_calc rbc_checker #(
  .NSOCK(NSOCK), .BND_W(BND_W), .TOM_W(TOM_W),
  .LOW_CEIL(LOW_CEIL), .LOW_SHIFT(LOW_SHIFT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .done        (done),
  .size_err    (size_err),
  .bound_bytes (bound_bytes),
  .top_mem     (top_mem),
  .top_low_mem (top_low_mem)
);

// File: tb/rank_boundary_calc_tb.sv
`timescale 1ns/1ps
module rank_boundary_calc_tb_top;
  typedef struct packed {
    logic [1:0]  pres;
    logic [7:0]  r0, c0, k0;
    logic [15:0] w0;
    logic [2:0]  n0;
    logic [7:0]  r1, c1, k1;
    logic [15:0] w1;
    logic [2:0]  n1;
    logic [7:0]  b0, b1;
    logic [15:0] tom, tolm;
    logic        err;
    logic [5:0]  a0, z0, a1, z1;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 8'h0D,8'h0A,8'd4,16'd64,3'd0, 8'h0D,8'h0A,8'd4,16'd64,3'd0, 8'd4,8'd8,16'd4,16'h2000,1'b0, 6'd31,6'd0,6'd31,6'd0},
    '{2'b01, 8'h0E,8'h0A,8'd8,16'd72,3'd1, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'd16,8'd32,16'd16,16'h8000,1'b0, 6'd33,6'd33,6'd0,6'd0},
    '{2'b11, 8'h0F,8'h0B,8'd8,16'd64,3'd0, 8'h0F,8'h0B,8'd8,16'd64,3'd0, 8'd64,8'd128,16'd64,16'hC000,1'b0, 6'd35,6'd0,6'd35,6'd0},
    '{2'b11, 8'hDE,8'h9A,8'd8,16'd72,3'd1, 8'h0D,8'h0A,8'd4,16'd64,3'd0, 8'd16,8'd36,16'd18,16'h9000,1'b0, 6'd33,6'd31,6'd31,6'd0},
    '{2'b00, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'd0,8'd0,16'd0,16'h0000,1'b0, 6'd0,6'd0,6'd0,6'd0},
    '{2'b10, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'h0C,8'h09,8'd4,16'd64,3'd0, 8'd0,8'd1,16'd0,16'h0000,1'b0, 6'd0,6'd0,6'd29,6'd0},
    '{2'b11, 8'h0D,8'h0A,8'd4,16'd64,3'd0, 8'h0D,8'h0A,8'd4,16'd65,3'd0, 8'd0,8'd0,16'd0,16'h0000,1'b1, 6'd0,6'd0,6'd0,6'd0},
    '{2'b01, 8'hD0,8'h0A,8'd4,16'd64,3'd0, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'd0,8'd0,16'd0,16'h0000,1'b1, 6'd0,6'd0,6'd0,6'd0},
    '{2'b01, 8'h0D,8'h0A,8'd4,16'd64,3'd2, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'd0,8'd0,16'd0,16'h0000,1'b1, 6'd0,6'd0,6'd0,6'd0},
    '{2'b01, 8'h0B,8'h09,8'd4,16'd64,3'd0, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'd0,8'd0,16'd0,16'h0000,1'b1, 6'd0,6'd0,6'd0,6'd0},
    '{2'b11, 8'h0D,8'h0A,8'd4,16'd64,3'd0, 8'h0D,8'h0A,8'd0,16'd64,3'd0, 8'd0,8'd0,16'd0,16'h0000,1'b1, 6'd0,6'd0,6'd0,6'd0},
    '{2'b11, 8'h0D,8'h0A,8'd4,16'd64,3'd1, 8'h0D,8'h0A,8'd4,16'd64,3'd1, 8'd4,8'd12,16'd12,16'h6000,1'b0, 6'd31,6'd31,6'd31,6'd31},
    '{2'b11, 8'h0F,8'h0A,8'd8,16'd64,3'd0, 8'h0E,8'h0A,8'd8,16'd64,3'd0, 8'd32,8'd48,16'd24,16'hC000,1'b0, 6'd34,6'd0,6'd33,6'd0},
    '{2'b01, 8'h0D,8'h0A,8'd4,16'd64,3'd0, 8'h00,8'h00,8'd0,16'd0,3'd0, 8'd4,8'd4,16'd2,16'h1000,1'b0, 6'd31,6'd0,6'd0,6'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  slot_present = '0;
  logic [15:0] row_bits_fld = '0, col_bits_fld = '0, bank_cnt_fld = '0;
  logic [31:0] data_width_fld = '0;
  logic [5:0]  rank_code_fld = '0;
  logic        done, size_err;
  logic [31:0] bound_bytes;
  logic [23:0] side_log2;
  logic [15:0] top_mem, top_low_mem;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rank_boundary_calc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .slot_present(slot_present), .row_bits_fld(row_bits_fld),
    .col_bits_fld(col_bits_fld), .bank_cnt_fld(bank_cnt_fld),
    .data_width_fld(data_width_fld), .rank_code_fld(rank_code_fld),
    .done(done), .size_err(size_err), .bound_bytes(bound_bytes),
    .side_log2(side_log2), .top_mem(top_mem), .top_low_mem(top_low_mem)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    slot_present   = v.pres;
    row_bits_fld   = {v.r1, v.r0};
    col_bits_fld   = {v.c1, v.c0};
    bank_cnt_fld   = {v.k1, v.k0};
    data_width_fld = {v.w1, v.w0};
    rank_code_fld  = {v.n1, v.n0};
  endtask

  // Accept at a rising edge, then sample done at the next four falling edges.
  task automatic run(input vec_t v, input vec_t busy_v, input bit disturb, output int lat);
    @(negedge clk);
    apply(v);
    in_valid = 1'b1;
    @(posedge clk);
    lat = -1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (c == 0) begin
        check("R8 in_ready low while busy", {31'd0, in_ready}, 32'd0);
        if (disturb) apply(busy_v);
        else in_valid = 1'b0;
      end
      if (done && lat < 0) lat = c;
    end
    in_valid = 1'b0;
  endtask

  task automatic check_results(input vec_t e, input string tag);
    check({tag, " R5 bound bytes"}, bound_bytes, {e.b1, e.b1, e.b0, e.b0});
    check({tag, " R6 top_mem"}, {16'd0, top_mem}, {16'd0, e.tom});
    check({tag, " R7 top_low_mem"}, {16'd0, top_low_mem}, {16'd0, e.tolm});
    check({tag, " R3/R4 size_err"}, {31'd0, size_err}, {31'd0, e.err});
    check({tag, " R1/R2 side_log2"}, {8'd0, side_log2}, {8'd0, e.z1, e.a1, e.z0, e.a0});
  endtask

  initial begin
    int lat;
    vec_t held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 in_ready after reset", {31'd0, in_ready}, 32'd1);
    check("R9 done after reset", {31'd0, done}, 32'd0);
    check("R9 size_err after reset", {31'd0, size_err}, 32'd0);
    check("R9 outputs after reset", {bound_bytes ^ {8'd0, side_log2}}, 32'd0);
    check("R9 tom/tolm after reset", {top_mem, top_low_mem}, 32'd0);

    // Table walk; R10 also covered as a good vector follows an error vector.
    for (int i = 0; i < NV; i++) begin
      run(VECS[i], VECS[i], 1'b0, lat);
      check($sformatf("v%0d R8 done latency", i), lat, 32'd3);
      check_results(VECS[i], $sformatf("v%0d", i));
    end

    // R8: inputs changed and held valid while busy have no effect
    run(VECS[0], VECS[2], 1'b1, lat);
    check("R8 latency with busy input change", lat, 32'd3);
    check_results(VECS[0], "busy-change R8");

    // R10: results hold while idle
    held = VECS[0];
    repeat (5) @(negedge clk);
    check("R10 done stays low while idle", {31'd0, done}, 32'd0);
    check_results(held, "idle-hold R10");

    // R10: error then fresh accept clears size_err
    run(VECS[9], VECS[9], 1'b0, lat);
    check("R4 error run flags", {31'd0, size_err}, 32'd1);
    run(VECS[12], VECS[12], 1'b0, lat);
    check("R10 size_err cleared by new run", {31'd0, size_err}, 32'd0);
    check("R7 clamp at 24 exactly", {16'd0, top_low_mem}, 32'h0000C000);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule